// File: doc/BRIEF.md
# Hashed Page Table Walker

This block is a sequential translation engine. It is started after a block-translation lookup has missed, and it searches a hashed page table in memory for the entry that maps an effective address. At start it picks one of sixteen segment registers using the top four address bits. It keeps the low 24 bits of that register as the segment id. From the segment id and the page index it forms a 23-bit hash, and the hash selects a group of eight 8-byte entries. The walker reads the first word of each entry in turn and compares it with a search key. If all eight miss, it complements the hash and searches a second group with a key that has its pass bit set.

On a match it reads the entry's second word and builds a 36-bit physical address. If both groups miss, or the table base is zero, the walk ends in a fault. For a data access the fault also loads a status word and a fault-address register and pulses a data-storage fault. All memory traffic goes through one 32-bit word-read port with a valid/ready request and a valid-only response. The walker keeps at most one read in flight.

Top module: `hpt_walker`

## Requirements
- R1: At start the walker drives `seg_idx_o` with address bits [31:28]. It keeps bits [23:0] of `seg_data_i` as the segment id, and bits [31:24] have no effect.
- R2: First-pass hash h = (address bits [27:12] XOR segment id) AND 0x7FFFFF. The read address of slot s is (table_base AND 0xFFFF0000) + (h[9:0] << 6) + (((h >> 10) AND table_base[8:0]) << 16) + 8*s.
- R3: A first-pass entry matches only when its first word equals {1, segment id[23:0], 0, address bits [27:22]}: bit 31 set, id in bits 30:7, pass bit 6 clear, page tag in bits 5:0.
- R4: Only after all eight first-pass slots miss does the walker search a second group. That group uses hash (NOT h) AND 0x7FFFFF and the same key with bit 6 set.
- R5: Slots are read in the order 0 to 7 and the search stops at the first match. No further first words are read after a match.
- R6: On a match the walker reads the word at slot address + 4 and reports a hit. paddr_o = {w[11:9], w[2], w[31:12], address bits [11:0]}, where w is that word.
- R7: A zero table base ends the walk in a fault without any memory read.
- R8: A data-side fault sets `fault_status_o` to bit 30, plus bit 25 for a write. It loads `fault_addr_o` with the effective address and pulses `dfault_o` together with `done_o`.
- R9: An instruction-side fault reports `fault_o` but leaves `dfault_o` low and leaves `fault_status_o` and `fault_addr_o` unchanged.
- R10: A read request stays valid with a stable address until it is accepted. No new request is made until the previous response has arrived.
- R11: `done_o` is high for exactly one cycle per walk. In that cycle exactly one of `hit_o` and `fault_o` is high, and neither is high at any other time.
- R12: A start pulse during a walk is ignored. The walk in progress completes with its own result and read sequence.
- R13: After reset, done, hit, fault, data fault, the request valid, the status, the fault address and the physical address are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Starts a walk when the walker is idle |
| ea_i | input | 32 | Effective address to translate |
| is_data_i | input | 1 | 1 for a data access, 0 for an instruction fetch |
| is_write_i | input | 1 | 1 for a store access |
| table_base_i | input | 32 | Table origin in [31:16], group-select mask in [8:0] |
| seg_idx_o | output | 4 | Segment register index (address bits [31:28]) |
| seg_data_i | input | 32 | Selected segment register contents, same cycle |
| mem_req_valid_o | output | 1 | Word read request valid |
| mem_req_ready_i | input | 1 | Memory accepts the request |
| mem_req_addr_o | output | 32 | Byte address of the requested word |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_data_i | input | 32 | Read data |
| done_o | output | 1 | One-cycle completion pulse |
| hit_o | output | 1 | Walk found a mapping (with done) |
| fault_o | output | 1 | Walk failed (with done) |
| paddr_o | output | 36 | Physical address of the last hit |
| dfault_o | output | 1 | Data-storage fault pulse (with done) |
| fault_status_o | output | 32 | Status of the last data-side fault |
| fault_addr_o | output | 32 | Effective address of the last data-side fault |

## Verification
The assertions assume that memory gives exactly one response per accepted request, and never a response while no read is outstanding. The bench memory model only raises a response after it has accepted a request. It varies the ready stalls and the response latency between one and two cycles. The assertions also assume that `seg_data_i` is valid in the start cycle. The bench drives it combinationally from a fixed array of segment registers whose upper bits are non-zero. The start-ignored rule depends on no input being sampled mid-walk, so the bench pulses start with a different address in the middle of a long walk.

// File: rtl/hpt_walker_pkg.sv
// Shared constants and types of the hashed page table walker.
// Assumes a 32-bit effective address and a 36-bit physical address.
package hpt_walker_pkg;
    localparam int EA_W        = 32;
    localparam int PA_W        = 36;
    localparam int SEGID_W     = 24;
    localparam int HASH_W      = 23;
    localparam int MASK_W      = 9;
    localparam int LOW_HASH_W  = 10;
    localparam int GROUP_SLOTS = 8;
    localparam int SLOT_W      = $clog2(GROUP_SLOTS);
    localparam int ENTRY_SHIFT = 3;
    localparam int GROUP_SHIFT = 6;
    localparam int PAGE_SHIFT  = 12;
    localparam int ST_NOTRANS  = 30;
    localparam int ST_STORE    = 25;

    typedef enum logic [1:0] {
        W_IDLE     = 2'd0,
        W_ISSUE    = 2'd1,
        W_WAIT_KEY = 2'd2,
        W_WAIT_RPN = 2'd3
    } walk_state_t;
endpackage

// File: rtl/hpt_hash_unit.sv
// Forms the read address of one group slot and the search key for one pass.
// Purely combinational. Assumes the group-select mask sits in base[8:0]
// and the table origin in base[31:16].
module hpt_hash_unit
    import hpt_walker_pkg::*;
(
    input  logic [EA_W-1:0]    ea_i,
    input  logic [SEGID_W-1:0] seg_id_i,
    input  logic [31:0]        base_i,
    input  logic               second_i,
    input  logic [SLOT_W-1:0]  slot_i,
    output logic [31:0]        entry_addr_o,
    output logic [31:0]        key_o
);
    localparam int PAD_W = 32 - MASK_W - LOW_HASH_W - GROUP_SHIFT;

    logic [HASH_W-1:0] hash_first;
    logic [HASH_W-1:0] hash_sel;
    logic [MASK_W-1:0] hi_sel;
    logic [31:0]       group_off;

    // hash for the current pass, then the group offset inside the table
    always_comb begin
        hash_first = {{(HASH_W-16){1'b0}}, ea_i[27:12]} ^ seg_id_i[HASH_W-1:0];
        hash_sel   = second_i ? ~hash_first : hash_first;
        hi_sel     = hash_sel[LOW_HASH_W +: MASK_W] & base_i[MASK_W-1:0];
        group_off  = {{PAD_W{1'b0}}, hi_sel, hash_sel[LOW_HASH_W-1:0], {GROUP_SHIFT{1'b0}}};
    end

    // slot address inside the group
    assign entry_addr_o = {base_i[31:16], 16'h0000} + group_off
                        + {{(32-SLOT_W-ENTRY_SHIFT){1'b0}}, slot_i, {ENTRY_SHIFT{1'b0}}};

    // search key: valid bit, segment id, pass bit, page tag
    assign key_o = {1'b1, seg_id_i, second_i, ea_i[27:22]};
endmodule

// File: rtl/hpt_rd_port.sv
// Single-outstanding word read port. A one-cycle issue pulse loads the
// address; the request is held until accepted, then the port waits for
// exactly one response. Assumes issue only arrives while the port is idle.
module hpt_rd_port (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        issue_i,
    input  logic [31:0] addr_i,
    output logic        req_valid_o,
    input  logic        req_ready_i,
    output logic [31:0] req_addr_o,
    input  logic        rsp_valid_i,
    input  logic [31:0] rsp_data_i,
    output logic        rsp_ok_o,
    output logic [31:0] rsp_data_o
);
    logic        pend_q;
    logic        rsp_wait_q;
    logic [31:0] addr_q;

    // request hold and response tracking
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q     <= 1'b0;
            rsp_wait_q <= 1'b0;
            addr_q     <= '0;
        end else begin
            if (issue_i) begin
                pend_q <= 1'b1;
                addr_q <= addr_i;
            end else if (pend_q && req_ready_i) begin
                pend_q     <= 1'b0;
                rsp_wait_q <= 1'b1;
            end
            if (rsp_wait_q && rsp_valid_i) begin
                rsp_wait_q <= 1'b0;
            end
        end
    end

    assign req_valid_o = pend_q;
    assign req_addr_o  = addr_q;
    assign rsp_ok_o    = rsp_wait_q && rsp_valid_i;
    assign rsp_data_o  = rsp_data_i;
endmodule

// File: rtl/hpt_result_unit.sv
// Builds the physical address from a matched entry's second word and the
// fault status word for a data-side failure. Combinational.
module hpt_result_unit
    import hpt_walker_pkg::*;
(
    input  logic [EA_W-1:0] ea_i,
    input  logic [31:0]     word_i,
    input  logic            is_write_i,
    output logic [PA_W-1:0] paddr_o,
    output logic [31:0]     status_o
);
    // extended bits above the page number, then the page offset
    assign paddr_o = {word_i[11:9], word_i[2], word_i[31:PAGE_SHIFT], ea_i[PAGE_SHIFT-1:0]};

    // no-translation flag, plus store flag for a write
    always_comb begin
        status_o             = '0;
        status_o[ST_NOTRANS] = 1'b1;
        status_o[ST_STORE]   = is_write_i;
    end
endmodule

// File: rtl/hpt_walker.sv
// Hashed page table walker. On start it latches the address, the segment id
// and the table base. It then probes up to eight slots of the first-pass
// group and eight of the second-pass group, and reads the second word of
// the first matching slot. Assumes seg_data_i is valid in the start cycle
// and that memory returns one response per accepted request.
module hpt_walker
    import hpt_walker_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [EA_W-1:0] ea_i,
    input  logic            is_data_i,
    input  logic            is_write_i,
    input  logic [31:0]     table_base_i,
    output logic [3:0]      seg_idx_o,
    input  logic [31:0]     seg_data_i,
    output logic            mem_req_valid_o,
    input  logic            mem_req_ready_i,
    output logic [31:0]     mem_req_addr_o,
    input  logic            mem_rsp_valid_i,
    input  logic [31:0]     mem_rsp_data_i,
    output logic            done_o,
    output logic            hit_o,
    output logic            fault_o,
    output logic [PA_W-1:0] paddr_o,
    output logic            dfault_o,
    output logic [31:0]     fault_status_o,
    output logic [31:0]     fault_addr_o
);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(GROUP_SLOTS - 1);

    walk_state_t        state_q, state_d;
    logic [EA_W-1:0]    ea_q;
    logic [SEGID_W-1:0] seg_id_q;
    logic [31:0]        base_q;
    logic               is_data_q, is_write_q;
    logic               second_q, second_d;
    logic [SLOT_W-1:0]  slot_q, slot_d;

    logic               done_q, hit_q, fault_q, dfault_q;
    logic [PA_W-1:0]    paddr_q;
    logic [31:0]        status_q, far_q;

    logic [31:0]        entry_addr, key;
    logic               issue;
    logic [31:0]        issue_addr;
    logic               rsp_ok;
    logic [31:0]        rsp_data;
    logic               end_hit, end_fault;
    logic               f_data, f_write;
    logic [EA_W-1:0]    f_ea;
    logic [PA_W-1:0]    hit_paddr;
    logic [31:0]        f_status;

    assign seg_idx_o = ea_i[EA_W-1 -: 4];

    hpt_hash_unit u_hash (
        .ea_i         (ea_q),
        .seg_id_i     (seg_id_q),
        .base_i       (base_q),
        .second_i     (second_q),
        .slot_i       (slot_q),
        .entry_addr_o (entry_addr),
        .key_o        (key)
    );

    hpt_rd_port u_port (
        .clk         (clk),
        .rst_n       (rst_n),
        .issue_i     (issue),
        .addr_i      (issue_addr),
        .req_valid_o (mem_req_valid_o),
        .req_ready_i (mem_req_ready_i),
        .req_addr_o  (mem_req_addr_o),
        .rsp_valid_i (mem_rsp_valid_i),
        .rsp_data_i  (mem_rsp_data_i),
        .rsp_ok_o    (rsp_ok),
        .rsp_data_o  (rsp_data)
    );

    hpt_result_unit u_result (
        .ea_i       (f_ea),
        .word_i     (rsp_data),
        .is_write_i (f_write),
        .paddr_o    (hit_paddr),
        .status_o   (f_status)
    );

    // source of fault attributes: live inputs for the immediate zero-base case
    always_comb begin
        f_data  = (state_q == W_IDLE) ? is_data_i  : is_data_q;
        f_write = (state_q == W_IDLE) ? is_write_i : is_write_q;
        f_ea    = (state_q == W_IDLE) ? ea_i       : ea_q;
    end

    // next-state, read issue and walk termination
    always_comb begin
        state_d    = state_q;
        second_d   = second_q;
        slot_d     = slot_q;
        issue      = 1'b0;
        issue_addr = entry_addr;
        end_hit    = 1'b0;
        end_fault  = 1'b0;
        unique case (state_q)
            W_IDLE: begin
                if (start_i) begin
                    second_d = 1'b0;
                    slot_d   = '0;
                    if (table_base_i == 32'h0) begin
                        end_fault = 1'b1;
                    end else begin
                        state_d = W_ISSUE;
                    end
                end
            end
            W_ISSUE: begin
                issue   = 1'b1;
                state_d = W_WAIT_KEY;
            end
            W_WAIT_KEY: begin
                if (rsp_ok) begin
                    if (rsp_data == key) begin
                        issue      = 1'b1;
                        issue_addr = entry_addr + 32'd4;
                        state_d    = W_WAIT_RPN;
                    end else if (slot_q != LAST_SLOT) begin
                        slot_d  = slot_q + 1'b1;
                        state_d = W_ISSUE;
                    end else if (!second_q) begin
                        second_d = 1'b1;
                        slot_d   = '0;
                        state_d  = W_ISSUE;
                    end else begin
                        end_fault = 1'b1;
                        state_d   = W_IDLE;
                    end
                end
            end
            W_WAIT_RPN: begin
                if (rsp_ok) begin
                    end_hit = 1'b1;
                    state_d = W_IDLE;
                end
            end
            default: state_d = W_IDLE;
        endcase
    end

    // walk context capture at start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ea_q       <= '0;
            seg_id_q   <= '0;
            base_q     <= '0;
            is_data_q  <= 1'b0;
            is_write_q <= 1'b0;
        end else if (state_q == W_IDLE && start_i) begin
            ea_q       <= ea_i;
            seg_id_q   <= seg_data_i[SEGID_W-1:0];
            base_q     <= table_base_i;
            is_data_q  <= is_data_i;
            is_write_q <= is_write_i;
        end
    end

    // sequencer state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= W_IDLE;
            second_q <= 1'b0;
            slot_q   <= '0;
        end else begin
            state_q  <= state_d;
            second_q <= second_d;
            slot_q   <= slot_d;
        end
    end

    // result registers: one-cycle pulses and held fault/translation values
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q   <= 1'b0;
            hit_q    <= 1'b0;
            fault_q  <= 1'b0;
            dfault_q <= 1'b0;
            paddr_q  <= '0;
            status_q <= '0;
            far_q    <= '0;
        end else begin
            done_q   <= end_hit || end_fault;
            hit_q    <= end_hit;
            fault_q  <= end_fault;
            dfault_q <= end_fault && f_data;
            if (end_hit) begin
                paddr_q <= hit_paddr;
            end
            if (end_fault && f_data) begin
                status_q <= f_status;
                far_q    <= f_ea;
            end
        end
    end

    assign done_o         = done_q;
    assign hit_o          = hit_q;
    assign fault_o        = fault_q;
    assign dfault_o       = dfault_q;
    assign paddr_o        = paddr_q;
    assign fault_status_o = status_q;
    assign fault_addr_o   = far_q;
endmodule

// File: rtl/hpt_walker_chk.sv
// Protocol and completion checks for hpt_walker, attached by bind.
// Assumes memory responds only while a read is outstanding.
module hpt_walker_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        mem_req_valid_o,
    input logic        mem_req_ready_i,
    input logic [31:0] mem_req_addr_o,
    input logic        mem_rsp_valid_i,
    input logic        done_o,
    input logic        hit_o,
    input logic        fault_o,
    input logic        dfault_o
);
    logic outst_q;

    // tracks whether an accepted read still awaits its response
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            outst_q <= 1'b0;
        end else if (mem_req_valid_o && mem_req_ready_i) begin
            outst_q <= 1'b1;
        end else if (mem_rsp_valid_i) begin
            outst_q <= 1'b0;
        end
    end

    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid_o && !mem_req_ready_i) |=> (mem_req_valid_o && $stable(mem_req_addr_o)));

    // R10
    single_outst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid_o |-> !outst_q);

    // R10
    done_idle_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!mem_req_valid_o && !outst_q));

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R11
    done_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $onehot({hit_o, fault_o}));

    // R11
    result_only_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_o || fault_o) |-> done_o);

    // R8
    dfault_with_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dfault_o |-> (fault_o && done_o));
endmodule

bind hpt_walker hpt_walker_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .mem_req_valid_o (mem_req_valid_o),
    .mem_req_ready_i (mem_req_ready_i),
    .mem_req_addr_o  (mem_req_addr_o),
    .mem_rsp_valid_i (mem_rsp_valid_i),
    .done_o          (done_o),
    .hit_o           (hit_o),
    .fault_o         (fault_o),
    .dfault_o        (dfault_o)
);

// File: tb/hpt_walker_test.sv
module hpt_walker_test;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] BASE_A = 32'h00A0_0003;
    localparam logic [31:0] BASE_B = 32'h01C0_01FF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] ea_i = '0;
    logic        is_data_i = 1'b0;
    logic        is_write_i = 1'b0;
    logic [31:0] table_base_i = '0;
    logic [3:0]  seg_idx_o;
    logic [31:0] seg_data_i;
    logic        mem_req_valid_o;
    logic        mem_req_ready_i = 1'b0;
    logic [31:0] mem_req_addr_o;
    logic        mem_rsp_valid_i = 1'b0;
    logic [31:0] mem_rsp_data_i = '0;
    logic        done_o, hit_o, fault_o, dfault_o;
    logic [35:0] paddr_o;
    logic [31:0] fault_status_o, fault_addr_o;

    int checks = 0;
    int failures = 0;
    logic [31:0] segs [16];
    logic [31:0] mem [logic [31:0]];
    logic [31:0] seen [0:31];
    int          nseen = 0;
    logic [31:0] exp_seq [0:31];
    int          nexp;
    logic [31:0] last_status = '0;
    logic [31:0] last_far = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign seg_data_i = segs[seg_idx_o];

    hpt_walker uut (.*);

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] seg_id(input logic [31:0] ea);
        return segs[ea[31:28]] & 32'h00FF_FFFF;
    endfunction

    function automatic logic [31:0] slot_addr(input logic [31:0] ea, input logic [31:0] base,
                                              input int pass, input int slot);
        logic [31:0] h, off;
        h = (((ea >> 12) & 32'hFFFF) ^ seg_id(ea)) & 32'h7F_FFFF;
        if (pass != 0) h = (~h) & 32'h7F_FFFF;
        off = ((h & 32'h3FF) << 6) | (((h >> 10) & (base & 32'h1FF)) << 16);
        return (base & 32'hFFFF_0000) + off + 32'(slot * 8);
    endfunction

    function automatic logic [31:0] key_of(input logic [31:0] ea, input int pass);
        return 32'h8000_0000 | (seg_id(ea) << 7) | (pass != 0 ? 32'h40 : 32'h0) | ((ea >> 22) & 32'h3F);
    endfunction

    // memory model: variable ready stalls and 1..2 cycle response latency
    initial begin : mem_model
        int cyc = 0;
        bit busy = 0;
        int dly = 0;
        logic [31:0] raddr = '0;
        forever begin
            @(negedge clk);
            cyc++;
            mem_rsp_valid_i = 1'b0;
            mem_req_ready_i = 1'b0;
            if (busy) begin
                if (dly == 0) begin
                    mem_rsp_valid_i = 1'b1;
                    mem_rsp_data_i  = mem.exists(raddr) ? mem[raddr] : 32'h0;
                    busy = 0;
                end else begin
                    dly--;
                end
            end else if (mem_req_valid_o && (cyc % 3 != 0)) begin
                mem_req_ready_i = 1'b1;
                raddr = mem_req_addr_o;
                if (nseen < 32) seen[nseen] = mem_req_addr_o;
                nseen++;
                busy = 1;
                dly = cyc % 2;
            end
        end
    end

    task automatic run_walk(input string req, input logic [31:0] ea, input logic [31:0] base,
                            input bit dat, input bit wr, input bit exp_hit,
                            input int hp, input int hs, input bit glitch);
        bit got = 0;
        bit stop = 0;
        logic [31:0] w1;
        logic [35:0] exp_pa;
        bit ok;
        mem.delete();
        nexp = 0;
        w1 = '0;
        if (exp_hit) begin
            w1 = ((32'h5A000 + 32'(hs * 32'h111) + 32'(hp)) << 12) | (32'(hs % 8) << 9)
               | (32'(hp) << 2) | 32'h1FB;
            mem[slot_addr(ea, base, hp, hs)] = key_of(ea, hp);
            mem[slot_addr(ea, base, hp, hs) + 4] = w1;
            if (hp == 1) mem[slot_addr(ea, base, 0, hs)] = key_of(ea, 1);
            if (hp == 0 && hs > 0) mem[slot_addr(ea, base, 0, hs - 1)] = key_of(ea, 0) ^ 32'h1;
        end else begin
            mem[slot_addr(ea, base, 0, 2)] = key_of(ea, 1);
            mem[slot_addr(ea, base, 1, 5)] = key_of(ea, 0);
        end
        if (base != 0) begin
            for (int p = 0; p < 2; p++) begin
                for (int s = 0; s < 8; s++) begin
                    if (!stop) begin
                        exp_seq[nexp] = slot_addr(ea, base, p, s);
                        nexp++;
                        if (exp_hit && p == hp && s == hs) begin
                            exp_seq[nexp] = slot_addr(ea, base, p, s) + 4;
                            nexp++;
                            stop = 1;
                        end
                    end
                end
            end
        end
        @(negedge clk);
        nseen = 0;
        start_i = 1'b1; ea_i = ea; table_base_i = base; is_data_i = dat; is_write_i = wr;
        for (int c = 0; c < 600 && !got; c++) begin
            @(negedge clk);
            start_i = 1'b0;
            if (glitch && c == 6) begin
                start_i = 1'b1; ea_i = ea ^ 32'h3000_0000; is_data_i = 1'b1; is_write_i = 1'b1;
            end
            if (done_o) begin
                got = 1;
                chk(hit_o == exp_hit && fault_o == !exp_hit, {req, " R11 result"},
                    {hit_o, fault_o}, {exp_hit, !exp_hit});
                if (exp_hit) begin
                    exp_pa = {w1[11:9], w1[2], w1[31:12], ea[11:0]};
                    chk(paddr_o == exp_pa, {req, " R6 paddr"}, paddr_o, exp_pa);
                    chk(dfault_o == 1'b0, {req, " R11 no dfault on hit"}, dfault_o, 0);
                end else if (dat) begin
                    last_status = 32'h4000_0000 | (wr ? 32'h0200_0000 : 32'h0);
                    last_far = ea;
                    chk(dfault_o == 1'b1, {req, " R8 dfault"}, dfault_o, 1);
                end else begin
                    chk(dfault_o == 1'b0, {req, " R9 no dfault"}, dfault_o, 0);
                end
            end
        end
        start_i = 1'b0;
        chk(got, {req, " R11 done seen"}, got, 1);
        @(negedge clk);
        chk(done_o == 1'b0 && hit_o == 1'b0 && fault_o == 1'b0, {req, " R11 single pulse"},
            {done_o, hit_o, fault_o}, 0);
        chk(fault_status_o == last_status, {req, " R8 R9 status"}, fault_status_o, last_status);
        chk(fault_addr_o == last_far, {req, " R8 R9 fault address"}, fault_addr_o, last_far);
        chk(nseen == nexp, {req, " R5 R7 read count"}, nseen, nexp);
        ok = 1;
        for (int i = 0; i < nexp && i < nseen && i < 32; i++) begin
            if (seen[i] != exp_seq[i]) begin
                if (ok) chk(0, {req, " R2 R4 read address"}, seen[i], exp_seq[i]);
                ok = 0;
            end
        end
        if (ok) chk(1, {req, " R2 R4 read addresses"}, 0, 0);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : stim
        for (int i = 0; i < 16; i++) begin
            segs[i] = 32'h7300_0000 | (((32'(i) * 32'h0013_579B) ^ 32'h00AB_CDE1) & 32'h00FF_FFFF);
        end
        repeat (3) @(negedge clk);
        // R13 reset values
        chk(done_o == 0 && hit_o == 0 && fault_o == 0 && dfault_o == 0 && mem_req_valid_o == 0,
            "R13 reset pulses", {done_o, hit_o, fault_o, dfault_o, mem_req_valid_o}, 0);
        chk(fault_status_o == 0 && fault_addr_o == 0 && paddr_o == 0, "R13 reset values",
            fault_status_o ^ fault_addr_o, 0);
        rst_n = 1'b1;
        // R1 R2 R3 R5 R6: first-pass hits at every slot; R4: second-pass hits
        for (int p = 0; p < 2; p++) begin
            for (int s = 0; s < 8; s++) begin
                logic [31:0] ea;
                ea = (32'(s + 8 * p) << 28) | (((32'(s) * 32'h0135 + 32'(p) * 32'h2A7) << 12) & 32'h0FFF_F000)
                   | (32'hABC + 32'(s));
                run_walk(p == 0 ? "R3 R5 first pass hit" : "R4 second pass hit", ea,
                         p == 0 ? BASE_A : BASE_B, 1'b1, s[0], 1'b1, p, s, 1'b0);
            end
        end
        // R8 data write miss, data read miss
        run_walk("R8 data write miss", 32'h5432_1678, BASE_A, 1'b1, 1'b1, 1'b0, 0, 0, 1'b0);
        run_walk("R8 data read miss", 32'hC0FF_E124, BASE_B, 1'b1, 1'b0, 1'b0, 0, 0, 1'b0);
        // R9 instruction miss leaves status and address alone
        run_walk("R9 instruction miss", 32'h2468_ACE0, BASE_A, 1'b0, 1'b0, 1'b0, 0, 0, 1'b0);
        // R7 zero base: fault with no reads
        run_walk("R7 zero base data", 32'h9ABC_DEF0, 32'h0, 1'b1, 1'b1, 1'b0, 0, 0, 1'b0);
        run_walk("R7 zero base instruction", 32'h1357_9BDF, 32'h0, 1'b0, 1'b0, 1'b0, 0, 0, 1'b0);
        // R12 start during a walk is ignored
        run_walk("R12 restart ignored", 32'hE1E2_E3E4, BASE_B, 1'b0, 1'b0, 1'b1, 1, 7, 1'b1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule